// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds received characters for a UART register interface until software reads them. Each entry carries a data byte and four status bits: framing error, parity error, break and overrun. Characters come from the line receiver, or from the transmit side when internal loopback is on. A break seen on the line is stored as an entry of its own. A read strobe on the data register takes the head entry off the queue. The block drives empty and full flags, a receive interrupt status bit for a separate interrupt block, and a count of free slots that tells the upstream source how many more characters it may send.

A line-control bit selects the mode. With the bit set, the queue holds a parameterised number of entries (16 by default). With it clear, the queue is a single holding register. Any change of that bit flushes the queue. The receive interrupt status bit sets when a push brings the fill level up to the trigger level of one. It clears when a read leaves the queue empty. The status bits of each entry read out are kept in a receive-status register, and any write to that register clears it.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, rxEmpty=1, rxFull=0, rxIntStatus=0, rxStatus=0, readData=0, and spaceAvail=1, because the block starts in single-register mode.
- R2: Entries leave in the order they arrived. readData[7:0] is the data byte and readData[11:8] is the status, with bit 8 framing, bit 9 parity, bit 10 break and bit 11 overrun. A normal push stores rxFlags as bits 11:8.
- R3: spaceAvail equals the current depth minus the fill count, and rxFull is 1 exactly when the count equals the depth. A push into a full queue is dropped, and the count and the stored entries do not change.
- R4: While popRead is high, readData shows the head entry. The pop clears rxFull. A pop on an empty queue leaves the count and the read position unchanged, and rxEmpty stays 1.
- R5: rxIntStatus sets on the clock edge where a push raises the count to 1. It clears on the edge where a pop leaves the count at 0. No other event changes it, and a flush does not change it either.
- R6: Any change of fifoEnable empties the queue on the next edge: rxEmpty=1, rxFull=0, and both the count and the read position go to 0. A push or pop in that same cycle is discarded.
- R7: With fifoEnable=0 the depth is 1, so one push fills the queue and spaceAvail reads 0. With fifoEnable=1 the depth is DEPTH.
- R8: A pop copies the head entry's status bits into rxStatus. statusClear sets rxStatus to 0. If both happen in the same cycle, the pop wins.
- R9: While loopbackEn=1, rxValid and rxBreak are ignored and loopValid pushes loopData with status 0. While loopbackEn=0, loopValid is ignored.
- R10: rxBreak pushes the entry 0x400 (data 0, break bit 10 set). It takes priority over rxValid in the same cycle.
- R11: A pop and a push in the same cycle act as the pop followed by the push. On a queue holding one entry, this leaves the count at 1 and rxIntStatus at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEnable | input | 1 | Line-control mode bit: 1 selects the deep queue, 0 the single register |
| loopbackEn | input | 1 | Selects the loopback path as the receive source |
| rxValid | input | 1 | Push strobe from the line receiver |
| rxData | input | 8 | Received byte |
| rxFlags | input | 4 | Received status: framing, parity, break, overrun |
| rxBreak | input | 1 | Break detected on the line |
| loopValid | input | 1 | Push strobe from the loopback path |
| loopData | input | 8 | Loopback byte |
| popRead | input | 1 | Data-register read strobe |
| readData | output | 12 | Head entry, valid while popRead is high |
| statusClear | input | 1 | Write strobe to the receive-status register |
| rxStatus | output | 4 | Status bits of the last entry read out |
| rxEmpty | output | 1 | Queue empty |
| rxFull | output | 1 | Queue full |
| rxIntStatus | output | 1 | Receive interrupt status bit |
| spaceAvail | output | $clog2(DEPTH)+1 | Free slots at the current depth |

## Verification
The assertions assume that fifoEnable changes only while the queue is not being pushed or popped in ways that matter. A change only flushes the queue, so they still hold if it does not. They also assume that the source may present a push when spaceAvail is 0, since that is the case in which a push is dropped. The interrupt checks rely on every rise of rxIntStatus coming from a push into an empty queue. That holds for any input sequence, because a flush always empties the queue. The stimulus drives one register-bus operation per cycle, and combines pop with push or with statusClear only where a requirement names that combination.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic [3:0] status;
    logic [7:0] data;
  } rx_entry_t;

  typedef struct packed {
    logic pop;
    logic write;
    logic flush;
  } rxq_strobe_t;

  localparam logic [3:0] BREAK_STATUS = 4'b0100;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG_LEVEL = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic             pushReq,
  input  logic             popRead,
  output rxq_strobe_t      strobe,
  output logic [PTR_W-1:0] wrSlot,
  output logic [PTR_W-1:0] rdSlot,
  output logic             modeQ,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxIntStatus,
  output logic [CNT_W-1:0] spaceAvail
);
  logic [CNT_W-1:0] countQ, cntAfterPop, cntNext, depthCur;
  logic [PTR_W-1:0] posQ, posAfterPop, ptrMask;
  logic modeChange, popEff, pushOk;

  assign depthCur    = modeQ ? CNT_W'(DEPTH) : CNT_W'(1);
  assign ptrMask     = modeQ ? PTR_W'(DEPTH - 1) : '0;
  assign modeChange  = fifoEnable != modeQ;

  always_comb begin
    cntAfterPop = countQ;
    posAfterPop = posQ;
    popEff      = popRead && !modeChange;
    if (popEff && countQ != '0) begin
      cntAfterPop = countQ - 1'b1;
      posAfterPop = (posQ + 1'b1) & ptrMask;
    end
    pushOk  = pushReq && !modeChange && (cntAfterPop < depthCur);
    cntNext = cntAfterPop + CNT_W'(pushOk);
  end

  assign wrSlot       = (posAfterPop + cntAfterPop[PTR_W-1:0]) & ptrMask;
  assign rdSlot       = posQ;
  assign strobe.pop   = popEff;
  assign strobe.write = pushOk;
  assign strobe.flush = modeChange;
  assign spaceAvail   = depthCur - countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ      <= '0;
      posQ        <= '0;
      modeQ       <= 1'b0;
      rxEmpty     <= 1'b1;
      rxFull      <= 1'b0;
      rxIntStatus <= 1'b0;
    end else if (modeChange) begin
      countQ  <= '0;
      posQ    <= '0;
      modeQ   <= fifoEnable;
      rxEmpty <= 1'b1;
      rxFull  <= 1'b0;
    end else begin
      countQ  <= cntNext;
      posQ    <= posAfterPop;
      rxEmpty <= (cntNext == '0);
      if (pushOk)      rxFull <= (cntNext == depthCur);
      else if (popEff) rxFull <= 1'b0;
      if (pushOk && cntNext == CNT_W'(TRIG_LEVEL))
        rxIntStatus <= 1'b1;
      else if (popEff && (cntAfterPop + 1'b1) == CNT_W'(TRIG_LEVEL))
        rxIntStatus <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopbackEn,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic [3:0]       rxFlags,
  input  logic             rxBreak,
  input  logic             loopValid,
  input  logic [7:0]       loopData,
  input  logic             statusClear,
  input  rxq_strobe_t      strobe,
  input  logic [PTR_W-1:0] wrSlot,
  input  logic [PTR_W-1:0] rdSlot,
  output logic             pushReq,
  output logic [11:0]      readData,
  output logic [3:0]       rxStatus
);
  rx_entry_t newEntry;
  rx_entry_t slots [DEPTH];

  always_comb begin
    pushReq  = 1'b0;
    newEntry = '0;
    if (loopbackEn) begin
      pushReq       = loopValid;
      newEntry.data = loopData;
    end else if (rxBreak) begin
      pushReq         = 1'b1;
      newEntry.status = BREAK_STATUS;
    end else if (rxValid) begin
      pushReq  = 1'b1;
      newEntry = '{status: rxFlags, data: rxData};
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slots[s] <= '0;
      else if (strobe.write && wrSlot == PTR_W'(s))
        slots[s] <= newEntry;
    end
  end

  assign readData = slots[rdSlot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxStatus <= '0;
    else if (strobe.pop)  rxStatus <= slots[rdSlot].status;
    else if (statusClear) rxStatus <= '0;
  end
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG_LEVEL = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic             loopbackEn,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic [3:0]       rxFlags,
  input  logic             rxBreak,
  input  logic             loopValid,
  input  logic [7:0]       loopData,
  input  logic             popRead,
  output logic [11:0]      readData,
  input  logic             statusClear,
  output logic [3:0]       rxStatus,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxIntStatus,
  output logic [CNT_W-1:0] spaceAvail
);
  rxq_strobe_t      strobe;
  logic [PTR_W-1:0] wrSlot, rdSlot;
  logic             pushReq, modeQ;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) ctrl_i (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .pushReq(pushReq),
    .popRead(popRead), .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .modeQ(modeQ), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .rxIntStatus(rxIntStatus), .spaceAvail(spaceAvail)
  );

  rxq_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .loopbackEn(loopbackEn), .rxValid(rxValid),
    .rxData(rxData), .rxFlags(rxFlags), .rxBreak(rxBreak),
    .loopValid(loopValid), .loopData(loopData), .statusClear(statusClear),
    .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot), .pushReq(pushReq),
    .readData(readData), .rxStatus(rxStatus)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEnable,
  input logic             modeQ,
  input logic             pushReq,
  input logic             popRead,
  input logic             statusClear,
  input logic [3:0]       rxStatus,
  input logic             rxEmpty,
  input logic             rxFull,
  input logic             rxIntStatus,
  input logic [CNT_W-1:0] spaceAvail
);
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull));

  assert_full_means_no_space_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxFull == (spaceAvail == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && spaceAvail == '0 && !popRead && fifoEnable == modeQ)
      |=> (spaceAvail == '0) && rxFull);

  assert_int_rise_from_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIntStatus) |-> $past(rxEmpty));

  assert_int_fall_on_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxIntStatus) |-> $past(popRead));

  assert_mode_flush_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable != modeQ) |=> rxEmpty && !rxFull);

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusClear && !popRead) |=> rxStatus == 4'd0);
endmodule

bind rx_char_queue rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .modeQ(modeQ),
  .pushReq(pushReq), .popRead(popRead), .statusClear(statusClear),
  .rxStatus(rxStatus), .rxEmpty(rxEmpty), .rxFull(rxFull),
  .rxIntStatus(rxIntStatus), .spaceAvail(spaceAvail)
);

// File: tb/rx_char_queue_tb_top.sv
`timescale 1ns/1ps
module rx_char_queue_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  localparam int OP_PUSH = 0, OP_POP = 1, OP_BRK = 2, OP_LOOP = 3,
                 OP_POPPUSH = 4, OP_POPCLR = 5, OP_BRKRX = 6, OP_CLR = 7;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  data;
    logic [3:0]  flags;
    logic [11:0] expHead;
    logic [3:0]  expStat;
    logic        expEmpty;
    logic        expFull;
    logic        expInt;
    logic [4:0]  expSpace;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'hA1, 4'h0, 12'h000, 4'h0, 1'b0, 1'b0, 1'b1, 5'd15},
    '{3'd0, 8'hB2, 4'h3, 12'h000, 4'h0, 1'b0, 1'b0, 1'b1, 5'd14},
    '{3'd1, 8'h00, 4'h0, 12'h0A1, 4'h0, 1'b0, 1'b0, 1'b1, 5'd15},
    '{3'd1, 8'h00, 4'h0, 12'h3B2, 4'h3, 1'b1, 1'b0, 1'b0, 5'd16},
    '{3'd1, 8'h00, 4'h0, 12'h000, 4'h0, 1'b1, 1'b0, 1'b0, 5'd16},
    '{3'd2, 8'h00, 4'h0, 12'h000, 4'h0, 1'b0, 1'b0, 1'b1, 5'd15},
    '{3'd4, 8'hC3, 4'h0, 12'h400, 4'h4, 1'b0, 1'b0, 1'b1, 5'd15},
    '{3'd1, 8'h00, 4'h0, 12'h0C3, 4'h0, 1'b1, 1'b0, 1'b0, 5'd16},
    '{3'd3, 8'hD4, 4'h0, 12'h000, 4'h0, 1'b0, 1'b0, 1'b1, 5'd15},
    '{3'd1, 8'h00, 4'h0, 12'h0D4, 4'h0, 1'b1, 1'b0, 1'b0, 5'd16}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEnable = 0, loopbackEn = 0, rxValid = 0, rxBreak = 0, loopValid = 0;
  logic popRead = 0, statusClear = 0;
  logic [7:0] rxData = 0, loopData = 0;
  logic [3:0] rxFlags = 0;
  logic [11:0] readData;
  logic [3:0] rxStatus;
  logic rxEmpty, rxFull, rxIntStatus;
  logic [CNT_W-1:0] spaceAvail;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  rx_char_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .loopbackEn(loopbackEn),
    .rxValid(rxValid), .rxData(rxData), .rxFlags(rxFlags), .rxBreak(rxBreak),
    .loopValid(loopValid), .loopData(loopData), .popRead(popRead),
    .readData(readData), .statusClear(statusClear), .rxStatus(rxStatus),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxIntStatus(rxIntStatus),
    .spaceAvail(spaceAvail)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic doOp(input int op, input logic [7:0] d, input logic [3:0] f,
                      output logic [11:0] head);
    @(negedge clk);
    case (op)
      OP_PUSH:    begin rxValid = 1; rxData = d; rxFlags = f; end
      OP_POP:     popRead = 1;
      OP_BRK:     rxBreak = 1;
      OP_LOOP:    begin loopbackEn = 1; loopValid = 1; loopData = d;
                        rxValid = 1; rxData = 8'hEE; rxBreak = 1; end
      OP_POPPUSH: begin popRead = 1; rxValid = 1; rxData = d; rxFlags = f; end
      OP_POPCLR:  begin popRead = 1; statusClear = 1; end
      OP_BRKRX:   begin rxBreak = 1; rxValid = 1; rxData = d; rxFlags = f; end
      default:    statusClear = 1;
    endcase
    #1 head = readData;
    @(posedge clk);
    #1;
    rxValid = 0; rxBreak = 0; loopValid = 0; loopbackEn = 0;
    popRead = 0; statusClear = 0;
  endtask

  task automatic checkFlags(input string tag, input int e, input int fl,
                            input int it, input int sp);
    check({tag, " rxEmpty"}, int'(rxEmpty), e);
    check({tag, " rxFull"}, int'(rxFull), fl);
    check({tag, " rxIntStatus"}, int'(rxIntStatus), it);
    check({tag, " spaceAvail"}, int'(spaceAvail), sp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [11:0] head;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset state
    @(negedge clk);
    checkFlags("R1 reset", 1, 0, 0, 1);
    check("R1 rxStatus", int'(rxStatus), 0);
    check("R1 readData", int'(readData), 0);

    // R6/R7: switch to deep mode
    @(negedge clk) fifoEnable = 1;
    @(posedge clk); #1;
    checkFlags("R6 R7 enter deep mode", 1, 0, 0, DEPTH);

    // Vector table: R2 R4 R5 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      doOp(int'(VECS[i].op), VECS[i].data, VECS[i].flags, head);
      if (VECS[i].op == 3'(OP_POP) || VECS[i].op == 3'(OP_POPPUSH))
        check($sformatf("R2 R4 R11 vec%0d head", i), int'(head), int'(VECS[i].expHead));
      check($sformatf("R8 vec%0d rxStatus", i), int'(rxStatus), int'(VECS[i].expStat));
      checkFlags($sformatf("R5 R9 R10 vec%0d", i), int'(VECS[i].expEmpty),
                 int'(VECS[i].expFull), int'(VECS[i].expInt), int'(VECS[i].expSpace));
    end

    // R3: fill to full, then overflow
    for (int i = 0; i < DEPTH; i++) doOp(OP_PUSH, 8'(i), 4'h0, head);
    checkFlags("R3 filled", 0, 1, 1, 0);
    doOp(OP_PUSH, 8'hFF, 4'hF, head);
    checkFlags("R3 overflow dropped", 0, 1, 1, 0);
    for (int i = 0; i < DEPTH; i++) begin
      doOp(OP_POP, 8'h00, 4'h0, head);
      check($sformatf("R2 R3 drain %0d", i), int'(head), i);
      if (i == 0) check("R4 pop clears full", int'(rxFull), 0);
    end
    checkFlags("R3 R5 drained", 1, 0, 0, DEPTH);

    // R6: flush on mode change, interrupt bit kept (R5)
    for (int i = 0; i < 3; i++) doOp(OP_PUSH, 8'h40 + 8'(i), 4'h0, head);
    @(negedge clk) fifoEnable = 0;
    @(posedge clk); #1;
    checkFlags("R6 R5 flush", 1, 0, 1, 1);
    doOp(OP_POP, 8'h00, 4'h0, head);
    checkFlags("R4 R5 pop on empty", 1, 0, 0, 1);

    // R7: single register mode
    doOp(OP_PUSH, 8'h55, 4'h1, head);
    checkFlags("R7 single full", 0, 1, 1, 0);
    doOp(OP_PUSH, 8'h66, 4'h2, head);
    checkFlags("R7 R3 single overflow", 0, 1, 1, 0);
    doOp(OP_POP, 8'h00, 4'h0, head);
    check("R7 single head", int'(head), 12'h155);
    check("R8 status copy", int'(rxStatus), 1);
    checkFlags("R7 single drained", 1, 0, 0, 1);

    // R8: clear, and pop priority over clear
    doOp(OP_CLR, 8'h00, 4'h0, head);
    check("R8 status cleared", int'(rxStatus), 0);
    doOp(OP_PUSH, 8'h77, 4'h8, head);
    doOp(OP_POPCLR, 8'h00, 4'h0, head);
    check("R8 pop wins over clear", int'(rxStatus), 8);
    check("R8 head", int'(head), 12'h877);

    // R10: break beats rxValid in same cycle
    doOp(OP_BRKRX, 8'h99, 4'h1, head);
    doOp(OP_POP, 8'h00, 4'h0, head);
    check("R10 break priority", int'(head), 12'h400);

    finishRun();
  end
endmodule